// File: doc/BRIEF.md
# Two-Level Row-Hit-First DRAM Command Scheduler

This block sits in front of a single DRAM channel and decides which pending read request gets the command bus each cycle. Read requests from several cores arrive one per cycle, each carrying a bank, row, column, request identifier and core number. Each accepted request is stamped with a free-running arrival count and placed in the queue of its target bank. Every bank keeps track of which row it has open, if any, and runs its own timing counters.

Selection has two levels. Inside a bank, requests that hit the open row win over requests that miss it, and among requests with equal hit status the earliest arrival wins. That winner is offered to the channel only when the bank's timing allows its next command. The channel arbiter then takes the earliest arrival among the offered bank winners whose command also meets the channel-wide spacing rules. At most one command goes out per cycle. A request served from a row hit may therefore go ahead of an older request that needs its row changed. A request leaves its queue when its READ goes out, and the completion outputs report it in that same cycle.

Top module: `frfcfs_sched`

## Requirements
- R1: After reset no command and no completion is driven, `req_ready` is high, and every bank is closed, so the first command to any bank is an ACTIVATE.
- R2: Every accepted request completes exactly once. `done_valid`, `done_id` and `done_core` report it in the same cycle as its READ appears on the command outputs.
- R3: Within a bank, a request whose row equals the open row is served before any request that misses it, even an older one.
- R4: Within a bank, among requests of equal hit status the earliest arrival is served first. This still holds after the arrival counter wraps, as long as live requests lie within half its range.
- R5: Among bank winners that are ready, the channel issues the one with the earliest arrival, whatever the bank indices.
- R6: `cmd_kind` encodes 0 as no command, 1 as ACTIVATE, 2 as PRECHARGE and 3 as READ. A hit needs only a READ. A closed bank gets ACTIVATE then READ. A miss on an open bank gets PRECHARGE, then ACTIVATE of the target row, then READ.
- R7: On one bank, READ follows ACTIVATE by at least T_RCD cycles, PRECHARGE follows ACTIVATE by at least T_RAS cycles, and ACTIVATE follows PRECHARGE by at least T_RP cycles. With defaults 3, 5 and 3, a command that waits only on one of these rules issues exactly when that rule allows.
- R8: Across the channel, READs are at least T_CCD cycles apart and ACTIVATEs at least T_RRD cycles apart. With defaults 2 and 2, a command that waits only on one of these rules issues exactly when that rule allows.
- R9: `req_ready` is low while the queue of the bank named on `req_bank` is full. A request presented while it is low is not taken and never completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Target bank queue can take the request |
| req_bank | input | $clog2(NUM_BANKS) | Target bank |
| req_row | input | ROW_W | Target row |
| req_col | input | COL_W | Target column |
| req_id | input | ID_W | Request identifier |
| req_core | input | CORE_W | Issuing core |
| cmd_valid | output | 1 | A command is issued this cycle |
| cmd_kind | output | 2 | Command code (see R6) |
| cmd_bank | output | $clog2(NUM_BANKS) | Bank of the command |
| cmd_row | output | ROW_W | Row of the command |
| cmd_col | output | COL_W | Column of a READ |
| done_valid | output | 1 | A request retires this cycle |
| done_id | output | ID_W | Identifier of the retiring request |
| done_core | output | CORE_W | Core of the retiring request |

## Verification
The bound checker rebuilds each bank's open or closed state and the cycle gaps from the command stream alone. On every cycle it checks that no ACTIVATE goes to an open bank and no READ or PRECHARGE goes to a closed one, that every bank and channel spacing rule holds, and that completions line up with READs. Ordering cannot be shown by a per-cycle property: row-hit priority over older misses, the earliest arrival winning within a bank and across banks, and correct ordering after the arrival counter wraps. Exact issue cycles, backpressure on a full queue and the loss of nothing are also shown only by the directed scenarios.

// File: rtl/frfcfs_pkg.sv
// Shared types for the two-level read scheduler.
package frfcfs_pkg;
    typedef enum logic [1:0] {
        CMD_NONE = 2'd0,
        CMD_ACT  = 2'd1,
        CMD_PRE  = 2'd2,
        CMD_RD   = 2'd3
    } cmd_kind_e;
endpackage

// File: rtl/frfcfs_bank.sv
// One bank: request slots, open-row state, bank timing counters and the
// row-hit-first, then earliest-arrival selection. It offers its winner only
// when that winner's next command meets the bank timing. It assumes that live
// arrival stamps lie within half the stamp range, and that enq is never raised
// while full.
module frfcfs_bank
    import frfcfs_pkg::*;
#(
    parameter int DEPTH  = 4,
    parameter int ROW_W  = 8,
    parameter int COL_W  = 6,
    parameter int ID_W   = 8,
    parameter int CORE_W = 2,
    parameter int AGE_W  = 6,
    parameter int T_RCD  = 3,
    parameter int T_RP   = 3,
    parameter int T_RAS  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enq,
    input  logic [ROW_W-1:0]  enq_row,
    input  logic [COL_W-1:0]  enq_col,
    input  logic [ID_W-1:0]   enq_id,
    input  logic [CORE_W-1:0] enq_core,
    input  logic [AGE_W-1:0]  enq_age,
    output logic              full,
    output logic              cand_valid,
    output cmd_kind_e         cand_kind,
    output logic [AGE_W-1:0]  cand_age,
    output logic [ROW_W-1:0]  cand_row,
    output logic [COL_W-1:0]  cand_col,
    output logic [ID_W-1:0]   cand_id,
    output logic [CORE_W-1:0] cand_core,
    input  logic              grant
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int T_M1  = (T_RCD > T_RP) ? T_RCD : T_RP;
    localparam int T_MAX = (T_M1 > T_RAS) ? T_M1 : T_RAS;
    localparam int CNT_W = $clog2(T_MAX + 1);

    logic [DEPTH-1:0]  slot_v;
    logic [ROW_W-1:0]  row_q  [DEPTH];
    logic [COL_W-1:0]  col_q  [DEPTH];
    logic [ID_W-1:0]   id_q   [DEPTH];
    logic [CORE_W-1:0] core_q [DEPTH];
    logic [AGE_W-1:0]  age_q  [DEPTH];

    logic              open_v;
    logic [ROW_W-1:0]  open_row;
    logic [CNT_W-1:0]  rcd_c, rp_c, ras_c;

    logic              have;
    logic              best_hit;
    logic [IDX_W-1:0]  best;
    logic [IDX_W-1:0]  free_idx;
    logic              time_ok;

    // True when stamp a arrived before stamp b, modulo wraparound.
    function automatic logic older(input logic [AGE_W-1:0] a, input logic [AGE_W-1:0] b);
        logic [AGE_W-1:0] d;
        d = a - b;
        return d[AGE_W-1];
    endfunction

    // Pick the winner: row hits first, then the earliest arrival.
    always_comb begin
        have     = 1'b0;
        best_hit = 1'b0;
        best     = '0;
        for (int i = 0; i < DEPTH; i++) begin
            logic hit_i;
            hit_i = open_v && (row_q[i] == open_row);
            if (slot_v[i] && (!have || (hit_i && !best_hit) ||
                              ((hit_i == best_hit) && older(age_q[i], age_q[best])))) begin
                have     = 1'b1;
                best     = IDX_W'(i);
                best_hit = hit_i;
            end
        end
    end

    // Lowest free slot for the next arrival.
    always_comb begin
        free_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!slot_v[i]) free_idx = IDX_W'(i);
        end
    end

    // Next command for the winner, and the bank timing gate on it.
    always_comb begin
        if (!open_v) begin
            cand_kind = CMD_ACT;
            time_ok   = (rp_c == '0);
        end else if (best_hit) begin
            cand_kind = CMD_RD;
            time_ok   = (rcd_c == '0);
        end else begin
            cand_kind = CMD_PRE;
            time_ok   = (ras_c == '0);
        end
    end

    assign cand_valid = have && time_ok;
    assign cand_age   = age_q[best];
    assign cand_row   = row_q[best];
    assign cand_col   = col_q[best];
    assign cand_id    = id_q[best];
    assign cand_core  = core_q[best];
    assign full       = &slot_v;

    // Slot occupancy, open-row state and bank timing counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_v   <= '0;
            open_v   <= 1'b0;
            open_row <= '0;
            rcd_c    <= '0;
            rp_c     <= '0;
            ras_c    <= '0;
        end else begin
            if (rcd_c != '0) rcd_c <= rcd_c - 1'b1;
            if (rp_c  != '0) rp_c  <= rp_c  - 1'b1;
            if (ras_c != '0) ras_c <= ras_c - 1'b1;
            if (grant) begin
                case (cand_kind)
                    CMD_ACT: begin
                        open_v   <= 1'b1;
                        open_row <= row_q[best];
                        rcd_c    <= CNT_W'(T_RCD - 1);
                        ras_c    <= CNT_W'(T_RAS - 1);
                    end
                    CMD_PRE: begin
                        open_v <= 1'b0;
                        rp_c   <= CNT_W'(T_RP - 1);
                    end
                    CMD_RD:  slot_v[best] <= 1'b0;
                    default: ;
                endcase
            end
            if (enq) slot_v[free_idx] <= 1'b1;
        end
    end

    // Request payload capture on arrival.
    always_ff @(posedge clk) begin
        if (enq) begin
            row_q[free_idx]  <= enq_row;
            col_q[free_idx]  <= enq_col;
            id_q[free_idx]   <= enq_id;
            core_q[free_idx] <= enq_core;
            age_q[free_idx]  <= enq_age;
        end
    end
endmodule

// File: rtl/frfcfs_chan.sv
// Channel arbiter. Among offered bank winners whose command meets the channel
// spacing rules (READ to READ, ACTIVATE to ACTIVATE), it grants the earliest
// arrival. At most one grant is given per cycle. It assumes live stamps lie
// within half the stamp range.
module frfcfs_chan
    import frfcfs_pkg::*;
#(
    parameter int NB    = 4,
    parameter int AGE_W = 6,
    parameter int T_CCD = 2,
    parameter int T_RRD = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cand_valid [NB],
    input  cmd_kind_e             cand_kind  [NB],
    input  logic [AGE_W-1:0]      cand_age   [NB],
    output logic [NB-1:0]         grant,
    output logic                  gnt_any,
    output logic [$clog2(NB)-1:0] gnt_bank,
    output cmd_kind_e             gnt_kind
);
    localparam int BW    = $clog2(NB);
    localparam int T_MAX = (T_CCD > T_RRD) ? T_CCD : T_RRD;
    localparam int CNT_W = $clog2(T_MAX + 1);

    logic [CNT_W-1:0] ccd_c, rrd_c;

    // True when stamp a arrived before stamp b, modulo wraparound.
    function automatic logic older(input logic [AGE_W-1:0] a, input logic [AGE_W-1:0] b);
        logic [AGE_W-1:0] d;
        d = a - b;
        return d[AGE_W-1];
    endfunction

    // Earliest-arrival choice among eligible bank winners.
    always_comb begin
        gnt_any  = 1'b0;
        gnt_bank = '0;
        for (int b = 0; b < NB; b++) begin
            logic elig;
            elig = cand_valid[b] &&
                   !((cand_kind[b] == CMD_RD)  && (ccd_c != '0)) &&
                   !((cand_kind[b] == CMD_ACT) && (rrd_c != '0));
            if (elig && (!gnt_any || older(cand_age[b], cand_age[gnt_bank]))) begin
                gnt_any  = 1'b1;
                gnt_bank = BW'(b);
            end
        end
        gnt_kind = gnt_any ? cand_kind[gnt_bank] : CMD_NONE;
        grant    = '0;
        if (gnt_any) grant[gnt_bank] = 1'b1;
    end

    // Channel spacing counters, loaded when the matching command is granted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ccd_c <= '0;
            rrd_c <= '0;
        end else begin
            if (ccd_c != '0) ccd_c <= ccd_c - 1'b1;
            if (rrd_c != '0) rrd_c <= rrd_c - 1'b1;
            if (gnt_kind == CMD_RD)  ccd_c <= CNT_W'(T_CCD - 1);
            if (gnt_kind == CMD_ACT) rrd_c <= CNT_W'(T_RRD - 1);
        end
    end
endmodule

// File: rtl/frfcfs_sched.sv
// Top of the two-level read scheduler. It steers each accepted request into
// its bank, stamps it with an arrival count, and registers the granted
// command and completion. It assumes all timing parameters are at least 1.
module frfcfs_sched
    import frfcfs_pkg::*;
#(
    parameter int NUM_BANKS   = 4,
    parameter int QUEUE_DEPTH = 4,
    parameter int ROW_W       = 8,
    parameter int COL_W       = 6,
    parameter int ID_W        = 8,
    parameter int CORE_W      = 2,
    parameter int AGE_W       = 6,
    parameter int T_RCD       = 3,
    parameter int T_RP        = 3,
    parameter int T_RAS       = 5,
    parameter int T_CCD       = 2,
    parameter int T_RRD       = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req_valid,
    output logic                         req_ready,
    input  logic [$clog2(NUM_BANKS)-1:0] req_bank,
    input  logic [ROW_W-1:0]             req_row,
    input  logic [COL_W-1:0]             req_col,
    input  logic [ID_W-1:0]              req_id,
    input  logic [CORE_W-1:0]            req_core,
    output logic                         cmd_valid,
    output logic [1:0]                   cmd_kind,
    output logic [$clog2(NUM_BANKS)-1:0] cmd_bank,
    output logic [ROW_W-1:0]             cmd_row,
    output logic [COL_W-1:0]             cmd_col,
    output logic                         done_valid,
    output logic [ID_W-1:0]              done_id,
    output logic [CORE_W-1:0]            done_core
);
    localparam int BW = $clog2(NUM_BANKS);

    logic [NUM_BANKS-1:0] bank_full;
    logic [NUM_BANKS-1:0] grant;
    logic                 c_valid [NUM_BANKS];
    cmd_kind_e            c_kind  [NUM_BANKS];
    logic [AGE_W-1:0]     c_age   [NUM_BANKS];
    logic [ROW_W-1:0]     c_row   [NUM_BANKS];
    logic [COL_W-1:0]     c_col   [NUM_BANKS];
    logic [ID_W-1:0]      c_id    [NUM_BANKS];
    logic [CORE_W-1:0]    c_core  [NUM_BANKS];
    logic                 gnt_any;
    logic [BW-1:0]        gnt_bank;
    cmd_kind_e            gnt_kind;
    logic [AGE_W-1:0]     age_ctr;
    logic                 accept;

    assign req_ready = !bank_full[req_bank];
    assign accept    = req_valid && req_ready;

    // One bank unit for each bank.
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        frfcfs_bank #(
            .DEPTH(QUEUE_DEPTH), .ROW_W(ROW_W), .COL_W(COL_W), .ID_W(ID_W),
            .CORE_W(CORE_W), .AGE_W(AGE_W), .T_RCD(T_RCD), .T_RP(T_RP), .T_RAS(T_RAS)
        ) bank_i (
            .clk(clk), .rst_n(rst_n),
            .enq(accept && (req_bank == BW'(b))),
            .enq_row(req_row), .enq_col(req_col), .enq_id(req_id),
            .enq_core(req_core), .enq_age(age_ctr),
            .full(bank_full[b]),
            .cand_valid(c_valid[b]), .cand_kind(c_kind[b]), .cand_age(c_age[b]),
            .cand_row(c_row[b]), .cand_col(c_col[b]), .cand_id(c_id[b]),
            .cand_core(c_core[b]),
            .grant(grant[b])
        );
    end

    frfcfs_chan #(
        .NB(NUM_BANKS), .AGE_W(AGE_W), .T_CCD(T_CCD), .T_RRD(T_RRD)
    ) chan_i (
        .clk(clk), .rst_n(rst_n),
        .cand_valid(c_valid), .cand_kind(c_kind), .cand_age(c_age),
        .grant(grant), .gnt_any(gnt_any), .gnt_bank(gnt_bank), .gnt_kind(gnt_kind)
    );

    // Arrival stamp, advanced once for each accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) age_ctr <= '0;
        else if (accept) age_ctr <= age_ctr + 1'b1;
    end

    // Registered command and completion outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_valid  <= 1'b0;
            cmd_kind   <= CMD_NONE;
            cmd_bank   <= '0;
            cmd_row    <= '0;
            cmd_col    <= '0;
            done_valid <= 1'b0;
            done_id    <= '0;
            done_core  <= '0;
        end else begin
            cmd_valid  <= gnt_any;
            cmd_kind   <= gnt_kind;
            cmd_bank   <= gnt_bank;
            cmd_row    <= c_row[gnt_bank];
            cmd_col    <= c_col[gnt_bank];
            done_valid <= gnt_any && (gnt_kind == CMD_RD);
            done_id    <= c_id[gnt_bank];
            done_core  <= c_core[gnt_bank];
        end
    end
endmodule

// File: rtl/frfcfs_sched_chk.sv
// Protocol checker for the scheduler. It rebuilds bank open state and the
// command gaps from the command outputs alone. Gap counters saturate at 255,
// so all timing parameters must stay below that.
module frfcfs_sched_chk
    import frfcfs_pkg::*;
#(
    parameter int NB    = 4,
    parameter int T_RCD = 3,
    parameter int T_RP  = 3,
    parameter int T_RAS = 5,
    parameter int T_CCD = 2,
    parameter int T_RRD = 2
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  cmd_valid,
    input logic [1:0]            cmd_kind,
    input logic [$clog2(NB)-1:0] cmd_bank,
    input logic                  done_valid
);
    logic [NB-1:0] open_m;
    logic [7:0]    g_act [NB];
    logic [7:0]    g_pre [NB];
    logic [7:0]    g_rd, g_ch_act;
    logic          is_act, is_pre, is_rd;

    assign is_act = cmd_valid && (cmd_kind == CMD_ACT);
    assign is_pre = cmd_valid && (cmd_kind == CMD_PRE);
    assign is_rd  = cmd_valid && (cmd_kind == CMD_RD);

    // Shadow open state and saturating gaps since the last command of each kind.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_m   <= '0;
            g_rd     <= 8'hFF;
            g_ch_act <= 8'hFF;
            for (int b = 0; b < NB; b++) begin
                g_act[b] <= 8'hFF;
                g_pre[b] <= 8'hFF;
            end
        end else begin
            g_rd     <= is_rd  ? 8'd1 : ((g_rd     == 8'hFF) ? g_rd     : g_rd + 8'd1);
            g_ch_act <= is_act ? 8'd1 : ((g_ch_act == 8'hFF) ? g_ch_act : g_ch_act + 8'd1);
            for (int b = 0; b < NB; b++) begin
                logic here;
                here = (int'(cmd_bank) == b);
                g_act[b] <= (is_act && here) ? 8'd1 : ((g_act[b] == 8'hFF) ? g_act[b] : g_act[b] + 8'd1);
                g_pre[b] <= (is_pre && here) ? 8'd1 : ((g_pre[b] == 8'hFF) ? g_pre[b] : g_pre[b] + 8'd1);
                if (is_act && here) open_m[b] <= 1'b1;
                if (is_pre && here) open_m[b] <= 1'b0;
            end
        end
    end

    assert_act_on_closed_R6: assert property (@(posedge clk) disable iff (!rst_n)
        is_act |-> !open_m[cmd_bank]);
    assert_pre_on_open_R6: assert property (@(posedge clk) disable iff (!rst_n)
        is_pre |-> open_m[cmd_bank]);
    assert_rd_on_open_R6: assert property (@(posedge clk) disable iff (!rst_n)
        is_rd |-> open_m[cmd_bank]);
    assert_rcd_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        is_rd |-> (g_act[cmd_bank] >= 8'(T_RCD)));
    assert_ras_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        is_pre |-> (g_act[cmd_bank] >= 8'(T_RAS)));
    assert_rp_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        is_act |-> (g_pre[cmd_bank] >= 8'(T_RP)));
    assert_ccd_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        is_rd |-> (g_rd >= 8'(T_CCD)));
    assert_rrd_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        is_act |-> (g_ch_act >= 8'(T_RRD)));
    assert_done_with_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid == is_rd);
endmodule

bind frfcfs_sched frfcfs_sched_chk #(
    .NB(NUM_BANKS), .T_RCD(T_RCD), .T_RP(T_RP), .T_RAS(T_RAS),
    .T_CCD(T_CCD), .T_RRD(T_RRD)
) chk_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
    .cmd_bank(cmd_bank), .done_valid(done_valid)
);

// File: tb/frfcfs_sched_tb_top.sv
// Directed bench for the two-level read scheduler.
module frfcfs_sched_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NB = 4, BW = 2, ROW_W = 8, COL_W = 6, ID_W = 8, CORE_W = 2;
    localparam int T_RCD = 3, T_RP = 3, T_RAS = 5, T_CCD = 2, T_RRD = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [BW-1:0]     req_bank = '0;
    logic [ROW_W-1:0]  req_row = '0;
    logic [COL_W-1:0]  req_col = '0;
    logic [ID_W-1:0]   req_id = '0;
    logic [CORE_W-1:0] req_core = '0;
    logic              cmd_valid;
    logic [1:0]        cmd_kind;
    logic [BW-1:0]     cmd_bank;
    logic [ROW_W-1:0]  cmd_row;
    logic [COL_W-1:0]  cmd_col;
    logic              done_valid;
    logic [ID_W-1:0]   done_id;
    logic [CORE_W-1:0] done_core;

    always #(CLK_PERIOD / 2) clk = ~clk;

    frfcfs_sched #(
        .NUM_BANKS(NB), .QUEUE_DEPTH(4), .ROW_W(ROW_W), .COL_W(COL_W), .ID_W(ID_W),
        .CORE_W(CORE_W), .AGE_W(6), .T_RCD(T_RCD), .T_RP(T_RP), .T_RAS(T_RAS),
        .T_CCD(T_CCD), .T_RRD(T_RRD)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_bank(req_bank), .req_row(req_row), .req_col(req_col), .req_id(req_id),
        .req_core(req_core), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
        .cmd_bank(cmd_bank), .cmd_row(cmd_row), .cmd_col(cmd_col),
        .done_valid(done_valid), .done_id(done_id), .done_core(done_core)
    );

    int n_tot = 0, n_fail = 0;
    int cyc = 0;
    int n_cmd = 0;
    int lg_kind [256], lg_bank [256], lg_row [256], lg_id [256], lg_core [256], lg_cyc [256];
    int done_cnt [256];
    bit stress_on = 1'b0;
    bit finished = 1'b0;
    int exp_next [NB];
    int stress_done = 0, stress_other = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tot++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: log commands and completions away from the active edge.
    always @(negedge clk) begin
        if (rst_n && cmd_valid) begin
            lg_kind[n_cmd & 255] = int'(cmd_kind);
            lg_bank[n_cmd & 255] = int'(cmd_bank);
            lg_row[n_cmd & 255]  = int'(cmd_row);
            lg_id[n_cmd & 255]   = int'(done_id);
            lg_core[n_cmd & 255] = int'(done_core);
            lg_cyc[n_cmd & 255]  = cyc;
            n_cmd++;
            if (stress_on && cmd_kind != 2'd3) stress_other++;
        end
        if (rst_n && done_valid) begin
            done_cnt[done_id] = done_cnt[done_id] + 1;
            if (stress_on) begin
                chk(int'(done_id) == exp_next[cmd_bank], "R4 stress order per bank",
                    int'(done_id), exp_next[cmd_bank]);
                chk(int'(done_core) == int'(done_id) % 4, "R2 stress done_core",
                    int'(done_core), int'(done_id) % 4);
                exp_next[cmd_bank] = exp_next[cmd_bank] + 4;
                stress_done++;
            end
        end
    end

    task automatic send(input int bank, input int row, input int col, input int id, input int core);
        req_valid = 1'b1;
        req_bank  = BW'(bank);
        req_row   = ROW_W'(row);
        req_col   = COL_W'(col);
        req_id    = ID_W'(id);
        req_core  = CORE_W'(core);
        #1;
        while (!req_ready) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        chk(cmd_valid == 1'b0, "R1 cmd_valid after reset", int'(cmd_valid), 0);
        chk(done_valid == 1'b0, "R1 done_valid after reset", int'(done_valid), 0);
        chk(req_ready == 1'b1, "R1 req_ready after reset", int'(req_ready), 1);
    endtask

    task automatic t_two_banks;
        int base;
        base = n_cmd;
        send(2, 1, 2, 1, 1);
        send(3, 1, 3, 2, 2);
        idle(15);
        chk(n_cmd - base == 4, "R6 closed banks need ACT+READ each", n_cmd - base, 4);
        chk(lg_kind[base] == 1 && lg_bank[base] == 2, "R1 first cmd is ACT bank2", lg_kind[base], 1);
        chk(lg_kind[base+1] == 1 && lg_bank[base+1] == 3, "R1 second cmd is ACT bank3", lg_kind[base+1], 1);
        chk(lg_cyc[base+1] - lg_cyc[base] == T_RRD, "R8 ACT to ACT gap",
            lg_cyc[base+1] - lg_cyc[base], T_RRD);
        chk(lg_kind[base+2] == 3 && lg_bank[base+2] == 2, "R6 READ bank2", lg_kind[base+2], 3);
        chk(lg_cyc[base+2] - lg_cyc[base] == T_RCD, "R7 ACT to READ gap",
            lg_cyc[base+2] - lg_cyc[base], T_RCD);
        chk(lg_id[base+2] == 1 && lg_core[base+2] == 1, "R2 done id/core with READ", lg_id[base+2], 1);
        chk(lg_id[base+3] == 2 && lg_core[base+3] == 2, "R2 second done id/core", lg_id[base+3], 2);
    endtask

    task automatic t_hit_first;
        int base;
        base = n_cmd;
        send(1, 2, 0, 3, 0);
        send(1, 3, 1, 4, 1);
        send(1, 2, 2, 5, 2);
        idle(25);
        chk(n_cmd - base == 6, "R6 command count hit/conflict mix", n_cmd - base, 6);
        chk(lg_kind[base] == 1 && lg_kind[base+1] == 3 && lg_kind[base+2] == 3 &&
            lg_kind[base+3] == 2 && lg_kind[base+4] == 1 && lg_kind[base+5] == 3,
            "R6 ACT RD RD PRE ACT RD", lg_kind[base+3], 2);
        chk(lg_id[base+1] == 3, "R4 first READ is earliest hit", lg_id[base+1], 3);
        chk(lg_id[base+2] == 5, "R3 younger hit before older miss", lg_id[base+2], 5);
        chk(lg_row[base+4] == 3, "R6 ACT opens target row", lg_row[base+4], 3);
        chk(lg_cyc[base+3] - lg_cyc[base] >= T_RAS, "R7 ACT to PRE gap",
            lg_cyc[base+3] - lg_cyc[base], T_RAS);
        chk(lg_cyc[base+4] - lg_cyc[base+3] == T_RP, "R7 PRE to ACT gap",
            lg_cyc[base+4] - lg_cyc[base+3], T_RP);
        chk(lg_id[base+5] == 4, "R2 missed request still completes", lg_id[base+5], 4);
    endtask

    task automatic t_channel_age;
        int base;
        base = n_cmd;
        send(3, 1, 4, 6, 0);
        send(3, 1, 5, 7, 1);
        send(2, 1, 6, 8, 2);
        idle(15);
        chk(n_cmd - base == 3, "R6 hits need only READ", n_cmd - base, 3);
        chk(lg_id[base] == 6, "R5 first READ", lg_id[base], 6);
        chk(lg_id[base+1] == 7, "R5 older bank3 before younger bank2", lg_id[base+1], 7);
        chk(lg_id[base+2] == 8, "R5 younger last", lg_id[base+2], 8);
        chk(lg_cyc[base+1] - lg_cyc[base] == T_CCD, "R8 READ to READ gap",
            lg_cyc[base+1] - lg_cyc[base], T_CCD);
    endtask

    task automatic t_backpressure;
        int base, j;
        base = n_cmd;
        for (int i = 0; i < 4; i++) send(0, 5 + i, i, 9 + i, 3);
        req_valid = 1'b1;
        req_bank  = 2'd0;
        req_row   = 8'd9;
        req_id    = 8'd200;
        #1;
        chk(req_ready == 1'b0, "R9 ready low on full bank", int'(req_ready), 0);
        @(negedge clk);
        req_valid = 1'b0;
        req_bank  = 2'd3;
        #1;
        chk(req_ready == 1'b1, "R9 ready high for other bank", int'(req_ready), 1);
        idle(60);
        for (int i = 0; i < 4; i++)
            chk(done_cnt[9 + i] == 1, "R2 queued request completes once", done_cnt[9 + i], 1);
        chk(done_cnt[200] == 0, "R9 refused request never completes", done_cnt[200], 0);
        j = 0;
        for (int k = base; k < n_cmd; k++) begin
            if (lg_kind[k & 255] == 3) begin
                chk(lg_id[k & 255] == 9 + j, "R4 misses served earliest first", lg_id[k & 255], 9 + j);
                j++;
            end
        end
    endtask

    task automatic t_stress;
        int rows [NB];
        rows[0] = 8; rows[1] = 3; rows[2] = 1; rows[3] = 1;
        for (int b = 0; b < NB; b++) exp_next[b] = 16 + b;
        stress_on = 1'b1;
        for (int i = 0; i < 80; i++) send(i % 4, rows[i % 4], i % 16, 16 + i, i % 4);
        idle(40);
        stress_on = 1'b0;
        chk(stress_done == 80, "R2 all stress requests complete", stress_done, 80);
        chk(stress_other == 0, "R3 all-hit traffic issues only READ", stress_other, 0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) done_cnt[i] = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_two_banks();
        t_hit_first();
        t_channel_age();
        t_backpressure();
        t_stress();
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_tot - n_fail, n_tot);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_tot++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
            $display("%0d/%0d checks passed", n_tot - n_fail, n_tot);
            $finish;
        end
    end
endmodule